// File: doc/BRIEF.md
# Semaphore Message Controller

This block sits in every tile of a multiprocessor network-on-chip and moves messages between tiles by a pull scheme. A core that wants to send has already written the payload into its own local memory. It hands the controller a destination tile, the buffer address and a word count. The controller keeps one pending flag per destination. If a message to that destination has not yet been acknowledged, it refuses the command in the same cycle. If the destination is free, it emits a semaphore-set packet and tells the core at once that it may carry on. It does not wait for the data to move.

On the receiving side, incoming semaphore-set packets land in a local bank with one entry per source tile. The consumer engine watches only this local bank. It picks one set entry by round-robin over source IDs and clears it. It then fetches the payload one word at a time with read requests to the producer's memory, streams each returned word out to the core, and finally sends a completion packet that frees the producer's pending flag.

The controller also serves read requests from other tiles by reading its own memory through a synchronous read port and returning the word. All network traffic uses one valid/ready packet port in each direction. When several packets compete for the transmit port, the order is: read responses first, then consumer packets, then semaphore-set packets.

Top module: `msg_sema_ctrl`

## Requirements
- R1: After reset, tx_valid, dout_valid, send_accept and send_busy are low, no destination is pending and no semaphore entry is set.
- R2: A send command to a destination that is not pending raises send_accept in the same cycle, once the transmit port takes the packet. The packet has kind 2'b00, src = my_id, dst = send_dst, data[3:0] = length minus one and data[19:4] = buffer address. The destination becomes pending.
- R3: A send command to a pending destination raises send_busy in the same cycle, emits no packet and changes no state. Other destinations are unaffected.
- R4: A completion packet (kind 2'b11) received from tile X clears the pending flag for X, so the next send to X is accepted.
- R5: A read request (kind 2'b01, data[15:0] = address) reads local memory at that address. The response (kind 2'b10, dst = requester, data = word) appears on tx after the second rising edge following acceptance. It is held stable while tx_ready is low.
- R6: A semaphore-set packet from source S stores an entry. The consumer then sends read requests to S for addresses addr, addr+1, … one at a time, each only after the previous response. Every response from S appears on dout with dout_src = S, and the last word raises dout_last.
- R7: After the last word, the consumer sends a completion packet (kind 2'b11, dst = S, data = 0).
- R8: Among set entries, the consumer serves the first source at or after (last served source + 1) mod 16. The search starts at source 0 after reset.
- R9: While tx_ready is low, a send to a free destination is neither accepted nor busy, and the destination stays free.
- R10: An incoming packet is dropped without effect if its dst differs from my_id, or if it is a semaphore-set packet with any data bit above bit 19 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id | input | 4 | This tile's ID |
| send_valid | input | 1 | Send command present |
| send_dst | input | 4 | Destination tile of the command |
| send_addr | input | 16 | Local buffer address of the payload |
| send_len | input | 4 | Payload length minus one |
| send_accept | output | 1 | Command taken, semaphore packet sent |
| send_busy | output | 1 | Command refused, destination pending |
| tx_valid | output | 1 | Outgoing packet valid |
| tx_ready | input | 1 | Network takes outgoing packet |
| tx_kind | output | 2 | Outgoing packet kind |
| tx_src | output | 4 | Outgoing source ID |
| tx_dst | output | 4 | Outgoing destination ID |
| tx_data | output | 32 | Outgoing payload word |
| rx_valid | input | 1 | Incoming packet valid |
| rx_ready | output | 1 | Controller takes incoming packet |
| rx_kind | input | 2 | Incoming packet kind |
| rx_src | input | 4 | Incoming source ID |
| rx_dst | input | 4 | Incoming destination ID |
| rx_data | input | 32 | Incoming payload word |
| mem_rd_en | output | 1 | Local memory read strobe |
| mem_rd_addr | output | 16 | Local memory read address |
| mem_rd_data | input | 32 | Read data, one cycle after strobe |
| dout_valid | output | 1 | Received message word valid |
| dout_src | output | 4 | Producer of the word |
| dout_data | output | 32 | Received message word |
| dout_last | output | 1 | Final word of the message |

## Verification
The timing is fixed per path:

- **Send commands.** send_accept, send_busy and the semaphore packet respond combinationally in the cycle of the command, so the bench reads them at the falling edge of that same cycle.
- **Pending flags.** A model of the per-destination flags is compared with send_busy at every falling edge while a command is present.
- **Served read requests.** The response is due after the second rising edge following acceptance. The bench samples tx_valid low after the first edge and after the second, then high after the third, rather than waiting for it loosely.
- **Consumer traffic.** A read request goes out one cycle after a semaphore entry is stored. Each dout word is combinational with its response. Outgoing packets and output words are therefore recorded into queues at each falling edge, and compared in order against expected values derived from the requirements.

// File: rtl/msg_pkg.sv
package msg_pkg;
  localparam int TILES  = 16;
  localparam int ID_W   = $clog2(TILES);
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    PK_SEMA  = 2'b00,
    PK_RDREQ = 2'b01,
    PK_RDRSP = 2'b10,
    PK_DONE  = 2'b11
  } pk_kind_e;
endpackage

// File: rtl/msg_pend_tbl.sv
module msg_pend_tbl
  import msg_pkg::*;
#(
  parameter int N = TILES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic [ID_W-1:0] qry_id,
  output logic            qry_busy
);
  logic [N-1:0] pend_q, pend_d, set_hit, clr_hit;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign set_hit[g] = set_en && (set_id == ID_W'(g));
    assign clr_hit[g] = clr_en && (clr_id == ID_W'(g));
  end

  always_comb begin
    pend_d = (pend_q & ~clr_hit) | set_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign qry_busy = pend_q[qry_id];

  // R4: a completion only ever arrives for a destination that is pending
  p_done_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> pend_q[clr_id]);
endmodule

// File: rtl/msg_sema_bank.sv
module msg_sema_bank
  import msg_pkg::*;
#(
  parameter int N      = TILES,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ID_W-1:0]   set_src,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [LEN_W-1:0]  set_len,
  input  logic              take_en,
  output logic              any_set,
  output logic [ID_W-1:0]   pick_src,
  output logic [ADDR_W-1:0] pick_addr,
  output logic [LEN_W-1:0]  pick_len
);
  logic [N-1:0]      vld_q, vld_d, hit;
  logic [ADDR_W-1:0] addr_q [N];
  logic [ADDR_W-1:0] addr_d [N];
  logic [LEN_W-1:0]  len_q  [N];
  logic [LEN_W-1:0]  len_d  [N];
  logic [ID_W-1:0]   rr_q, rr_d, cand;
  logic              found;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = set_en && (set_src == ID_W'(g));
  end

  // round-robin search starting at rr_q
  always_comb begin
    found    = 1'b0;
    pick_src = rr_q;
    cand     = rr_q;
    for (int k = 0; k < N; k++) begin
      cand = rr_q + ID_W'(k);
      if (!found && vld_q[cand]) begin
        found    = 1'b1;
        pick_src = cand;
      end
    end
  end

  assign any_set   = found;
  assign pick_addr = addr_q[pick_src];
  assign pick_len  = len_q[pick_src];

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    len_d  = len_q;
    rr_d   = rr_q;
    for (int k = 0; k < N; k++) begin
      if (hit[k]) begin
        vld_d[k]  = 1'b1;
        addr_d[k] = set_addr;
        len_d[k]  = set_len;
      end
    end
    if (take_en) begin
      vld_d[pick_src] = 1'b0;
      rr_d            = pick_src + ID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int k = 0; k < N; k++) begin
        addr_q[k] <= '0;
        len_q[k]  <= '0;
      end
    end else begin
      vld_q  <= vld_d;
      rr_q   <= rr_d;
      addr_q <= addr_d;
      len_q  <= len_d;
    end
  end

  // R6: one outstanding message per pair, so an entry is never overwritten
  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !vld_q[set_src]);
endmodule

// File: rtl/msg_rd_server.sv
module msg_rd_server
  import msg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_dst,
  output logic [WORD_W-1:0] rsp_data,
  input  logic              rsp_take
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_LAT, S_TX} sst_e;
  sst_e              st_q, st_d;
  logic [ID_W-1:0]   src_q, src_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;

  always_comb begin
    st_d   = st_q;
    src_d  = src_q;
    addr_d = addr_q;
    data_d = data_q;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        src_d  = req_src;
        addr_d = req_addr;
        st_d   = S_RD;
      end
      S_RD:  st_d = S_LAT;
      S_LAT: begin
        data_d = mem_rd_data;
        st_d   = S_TX;
      end
      S_TX:  if (rsp_take) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      src_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign req_ready   = (st_q == S_IDLE);
  assign mem_rd_en   = (st_q == S_RD);
  assign mem_rd_addr = addr_q;
  assign rsp_valid   = (st_q == S_TX);
  assign rsp_dst     = src_q;
  assign rsp_data    = data_q;

  // R5: a stalled response keeps its destination and word
  p_rsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_take |=> rsp_valid && $stable(rsp_data) && $stable(rsp_dst));
endmodule

// File: rtl/msg_consumer.sv
module msg_consumer
  import msg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_set,
  input  logic [ID_W-1:0]   pick_src,
  input  logic [ADDR_W-1:0] pick_addr,
  input  logic [LEN_W-1:0]  pick_len,
  output logic              take_en,
  output logic              req_valid,
  output pk_kind_e          req_kind,
  output logic [ID_W-1:0]   req_dst,
  output logic [WORD_W-1:0] req_data,
  input  logic              req_take,
  input  logic              rsp_valid,
  input  logic [ID_W-1:0]   rsp_src,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              dout_valid,
  output logic [ID_W-1:0]   dout_src,
  output logic [WORD_W-1:0] dout_data,
  output logic              dout_last
);
  typedef enum logic [1:0] {C_IDLE, C_REQ, C_WAIT, C_DONE} cst_e;
  cst_e              st_q, st_d;
  logic [ID_W-1:0]   src_q, src_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  last_q, last_d, idx_q, idx_d;
  logic              rsp_hit;

  assign rsp_hit = rsp_valid && (rsp_src == src_q);

  always_comb begin
    st_d       = st_q;
    src_d      = src_q;
    base_d     = base_q;
    last_d     = last_q;
    idx_d      = idx_q;
    take_en    = 1'b0;
    dout_valid = 1'b0;
    dout_last  = 1'b0;
    unique case (st_q)
      C_IDLE: if (any_set) begin
        take_en = 1'b1;
        src_d   = pick_src;
        base_d  = pick_addr;
        last_d  = pick_len;
        idx_d   = '0;
        st_d    = C_REQ;
      end
      C_REQ:  if (req_take) st_d = C_WAIT;
      C_WAIT: if (rsp_hit) begin
        dout_valid = 1'b1;
        dout_last  = (idx_q == last_q);
        if (idx_q == last_q) begin
          st_d = C_DONE;
        end else begin
          idx_d = idx_q + LEN_W'(1);
          st_d  = C_REQ;
        end
      end
      C_DONE: if (req_take) st_d = C_IDLE;
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      src_q  <= '0;
      base_q <= '0;
      last_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      base_q <= base_d;
      last_q <= last_d;
      idx_q  <= idx_d;
    end
  end

  assign req_valid = (st_q == C_REQ) || (st_q == C_DONE);
  assign req_kind  = (st_q == C_DONE) ? PK_DONE : PK_RDREQ;
  assign req_dst   = src_q;
  assign req_data  = (st_q == C_DONE) ? '0 : WORD_W'(base_q + ADDR_W'(idx_q));
  assign dout_src  = src_q;
  assign dout_data = rsp_data;

  // R7: the completion phase is entered only right after the final word
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == C_DONE) |-> $past(dout_last));
endmodule

// File: rtl/msg_sema_ctrl.sv
module msg_sema_ctrl
  import msg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id,
  input  logic              send_valid,
  input  logic [ID_W-1:0]   send_dst,
  input  logic [ADDR_W-1:0] send_addr,
  input  logic [LEN_W-1:0]  send_len,
  output logic              send_accept,
  output logic              send_busy,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [1:0]        tx_kind,
  output logic [ID_W-1:0]   tx_src,
  output logic [ID_W-1:0]   tx_dst,
  output logic [WORD_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [1:0]        rx_kind,
  input  logic [ID_W-1:0]   rx_src,
  input  logic [ID_W-1:0]   rx_dst,
  input  logic [WORD_W-1:0] rx_data,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              dout_valid,
  output logic [ID_W-1:0]   dout_src,
  output logic [WORD_W-1:0] dout_data,
  output logic              dout_last
);
  localparam int SEMA_USED = ADDR_W + LEN_W;

  // incoming packet decode
  logic dst_ok, sema_ok, rdreq_ok;
  logic rx_sema, rx_rdreq, rx_rdrsp, rx_done;

  assign dst_ok   = (rx_dst == my_id);
  assign sema_ok  = ((rx_data >> SEMA_USED) == '0);
  assign rdreq_ok = ((rx_data >> ADDR_W) == '0);
  assign rx_sema  = rx_valid && dst_ok && (rx_kind == PK_SEMA) && sema_ok;
  assign rx_rdreq = rx_valid && dst_ok && (rx_kind == PK_RDREQ) && rdreq_ok;
  assign rx_rdrsp = rx_valid && dst_ok && (rx_kind == PK_RDRSP);
  assign rx_done  = rx_valid && dst_ok && (rx_kind == PK_DONE);

  // sub-block wires
  logic              pend_busy, sema_take;
  logic              srv_ready, srv_v, srv_take;
  logic [ID_W-1:0]   srv_dst;
  logic [WORD_W-1:0] srv_data;
  logic              any_set, take_en;
  logic [ID_W-1:0]   pick_src;
  logic [ADDR_W-1:0] pick_addr;
  logic [LEN_W-1:0]  pick_len;
  logic              con_v, con_take;
  pk_kind_e          con_kind;
  logic [ID_W-1:0]   con_dst;
  logic [WORD_W-1:0] con_data;
  logic              sema_v;

  assign rx_ready = !rx_rdreq || srv_ready;

  msg_pend_tbl #(.N(TILES)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (sema_take),
    .set_id  (send_dst),
    .clr_en  (rx_done),
    .clr_id  (rx_src),
    .qry_id  (send_dst),
    .qry_busy(pend_busy)
  );

  msg_sema_bank #(.N(TILES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (rx_sema),
    .set_src  (rx_src),
    .set_addr (rx_data[LEN_W +: ADDR_W]),
    .set_len  (rx_data[LEN_W-1:0]),
    .take_en  (take_en),
    .any_set  (any_set),
    .pick_src (pick_src),
    .pick_addr(pick_addr),
    .pick_len (pick_len)
  );

  msg_rd_server #(.ADDR_W(ADDR_W)) u_srv (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (rx_rdreq),
    .req_src    (rx_src),
    .req_addr   (rx_data[ADDR_W-1:0]),
    .req_ready  (srv_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data),
    .rsp_valid  (srv_v),
    .rsp_dst    (srv_dst),
    .rsp_data   (srv_data),
    .rsp_take   (srv_take)
  );

  msg_consumer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_con (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_set   (any_set),
    .pick_src  (pick_src),
    .pick_addr (pick_addr),
    .pick_len  (pick_len),
    .take_en   (take_en),
    .req_valid (con_v),
    .req_kind  (con_kind),
    .req_dst   (con_dst),
    .req_data  (con_data),
    .req_take  (con_take),
    .rsp_valid (rx_rdrsp),
    .rsp_src   (rx_src),
    .rsp_data  (rx_data),
    .dout_valid(dout_valid),
    .dout_src  (dout_src),
    .dout_data (dout_data),
    .dout_last (dout_last)
  );

  // transmit arbitration: served reads, then consumer traffic, then sends
  assign sema_v      = send_valid && !pend_busy;
  assign srv_take    = srv_v && tx_ready;
  assign con_take    = con_v && !srv_v && tx_ready;
  assign sema_take   = sema_v && !srv_v && !con_v && tx_ready;
  assign send_accept = sema_take;
  assign send_busy   = send_valid && pend_busy;

  assign tx_valid = srv_v || con_v || sema_v;
  assign tx_src   = my_id;

  always_comb begin
    if (srv_v) begin
      tx_kind = PK_RDRSP;
      tx_dst  = srv_dst;
      tx_data = srv_data;
    end else if (con_v) begin
      tx_kind = con_kind;
      tx_dst  = con_dst;
      tx_data = con_data;
    end else begin
      tx_kind = PK_SEMA;
      tx_dst  = send_dst;
      tx_data = WORD_W'({send_addr, send_len});
    end
  end

  // R2: an accepted command leaves as a semaphore packet to its destination
  p_accept_sema_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_accept |-> tx_valid && (tx_kind == PK_SEMA) && (tx_dst == send_dst));
endmodule

// File: tb/test_msg_sema_ctrl.sv
module test_msg_sema_ctrl;
  import msg_pkg::*;
  localparam int AW = 16;
  localparam int LW = 4;
  localparam logic [3:0] ME = 4'd3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic send_valid, send_accept, send_busy;
  logic [3:0] send_dst, send_len;
  logic [AW-1:0] send_addr;
  logic tx_valid, tx_ready;
  logic [1:0] tx_kind;
  logic [3:0] tx_src, tx_dst;
  logic [31:0] tx_data;
  logic rx_valid, rx_ready;
  logic [1:0] rx_kind;
  logic [3:0] rx_src, rx_dst;
  logic [31:0] rx_data;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic dout_valid, dout_last;
  logic [3:0] dout_src;
  logic [31:0] dout_data;

  msg_sema_ctrl #(.ADDR_W(AW), .LEN_W(LW)) i_msg_sema_ctrl (
    .clk(clk), .rst_n(rst_n), .my_id(ME),
    .send_valid(send_valid), .send_dst(send_dst), .send_addr(send_addr), .send_len(send_len),
    .send_accept(send_accept), .send_busy(send_busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_src(tx_src),
    .tx_dst(tx_dst), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_kind(rx_kind), .rx_src(rx_src),
    .rx_dst(rx_dst), .rx_data(rx_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .dout_valid(dout_valid), .dout_src(dout_src), .dout_data(dout_data), .dout_last(dout_last)
  );

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { int kind; int src; int dst; longint data; } tx_rec_t;
  typedef struct { int src; longint data; bit last; } do_rec_t;
  tx_rec_t txq[$];
  do_rec_t doq[$];
  bit pend_m [16];

  function automatic logic [31:0] mem_fn(input logic [AW-1:0] a);
    return 32'hA500_0000 ^ (32'(a) * 32'd7);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_fn(mem_rd_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // per-clock monitor and pending-flag reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready)
        txq.push_back('{int'(tx_kind), int'(tx_src), int'(tx_dst), longint'(tx_data)});
      if (dout_valid)
        doq.push_back('{int'(dout_src), longint'(dout_data), bit'(dout_last)});
      if (send_valid) begin
        chk(send_busy == pend_m[send_dst], "R3", "busy vs pending model",
            send_busy, pend_m[send_dst]);
        if (send_accept) pend_m[send_dst] = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  task automatic send(input int dst, input int addr, input int lenc,
                      output bit acc, output bit busy);
    @(posedge clk); #1;
    send_valid = 1'b1; send_dst = 4'(dst); send_addr = AW'(addr); send_len = 4'(lenc);
    @(negedge clk);
    acc = send_accept; busy = send_busy;
    @(posedge clk); #1;
    send_valid = 1'b0;
  endtask

  task automatic inject(input int kind, input int src, input int dst, input logic [31:0] data);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_kind = 2'(kind); rx_src = 4'(src); rx_dst = 4'(dst); rx_data = data;
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    @(posedge clk); #1;
    rx_valid = 1'b0;
    if (kind == 3 && dst == int'(ME)) pend_m[src] = 1'b0;
  endtask

  task automatic expect_tx(input string req, input int kind, input int dst, input longint data);
    tx_rec_t r;
    while (txq.size() == 0) @(negedge clk);
    r = txq.pop_front();
    chk(r.kind == kind, req, "tx kind", r.kind, kind);
    chk(r.src == int'(ME), req, "tx src", r.src, ME);
    chk(r.dst == dst, req, "tx dst", r.dst, dst);
    chk(r.data == data, req, "tx data", r.data, data);
  endtask

  task automatic expect_dout(input string req, input int src, input longint data, input bit last);
    do_rec_t r;
    while (doq.size() == 0) @(negedge clk);
    r = doq.pop_front();
    chk(r.src == src, req, "dout src", r.src, src);
    chk(r.data == data, req, "dout data", r.data, data);
    chk(r.last == last, req, "dout last", r.last, last);
  endtask

  initial begin
    bit acc, busy;
    rst_n = 1'b0; send_valid = 1'b0; send_dst = '0; send_addr = '0; send_len = '0;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_kind = '0; rx_src = '0; rx_dst = '0; rx_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!tx_valid && !dout_valid, "R1", "outputs idle in reset", {tx_valid, dout_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !dout_valid && !send_busy && !send_accept, "R1", "outputs idle after reset",
        {tx_valid, dout_valid, send_busy, send_accept}, 0);

    // R2 accepted send
    send(5, 'h100, 2, acc, busy);
    chk(acc && !busy, "R2", "accept free destination", {acc, busy}, 2'b10);
    expect_tx("R2", 0, 5, ('h100 << 4) | 2);

    // R3 busy, no state change
    send(5, 'h200, 1, acc, busy);
    chk(!acc && busy, "R3", "refuse pending destination", {acc, busy}, 2'b01);
    send(5, 'h200, 1, acc, busy);
    chk(!acc && busy, "R3", "still pending after refusal", {acc, busy}, 2'b01);
    chk(txq.size() == 0, "R3", "no packet on refusal", txq.size(), 0);
    send(6, 'h300, 0, acc, busy);
    chk(acc, "R3", "other destination free", acc, 1);
    expect_tx("R3", 0, 6, ('h300 << 4) | 0);

    // R4 completion frees destination
    inject(3, 5, ME, 32'h0);
    send(5, 'h180, 15, acc, busy);
    chk(acc && !busy, "R4", "accept after completion", {acc, busy}, 2'b10);
    expect_tx("R4", 0, 5, ('h180 << 4) | 15);

    // R9 stalled network
    tx_ready = 1'b0;
    send(8, 'h50, 0, acc, busy);
    chk(!acc && !busy, "R9", "stall neither accept nor busy", {acc, busy}, 0);
    tx_ready = 1'b1;
    send(8, 'h50, 0, acc, busy);
    chk(acc, "R9", "destination still free after stall", acc, 1);
    expect_tx("R9", 0, 8, ('h50 << 4) | 0);

    // R5 read service and its latency
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_kind = 2'b01; rx_src = 4'd9; rx_dst = ME; rx_data = 32'h20;
    @(negedge clk);
    chk(rx_ready, "R5", "read request taken", rx_ready, 1);
    @(posedge clk); #1 rx_valid = 1'b0;
    @(negedge clk);
    chk(!tx_valid, "R5", "no response after 1st edge", tx_valid, 0);
    @(negedge clk);
    chk(!tx_valid, "R5", "no response after 2nd edge", tx_valid, 0);
    @(negedge clk);
    chk(tx_valid && tx_kind == 2'b10, "R5", "response after 3rd edge", tx_valid, 1);
    expect_tx("R5", 2, 9, mem_fn(16'h20));

    tx_ready = 1'b0;
    inject(1, 11, ME, 32'h33);
    repeat (4) @(negedge clk);
    chk(tx_valid && tx_data == mem_fn(16'h33) && tx_dst == 4'd11, "R5", "response held in stall",
        tx_data, mem_fn(16'h33));
    tx_ready = 1'b1;
    expect_tx("R5", 2, 11, mem_fn(16'h33));

    // R6 / R7 consumer pull
    inject(0, 7, ME, (32'h40 << 4) | 32'd1);
    expect_tx("R6", 1, 7, 'h40);
    inject(2, 7, ME, 32'h1111);
    expect_dout("R6", 7, 'h1111, 1'b0);
    expect_tx("R6", 1, 7, 'h41);
    inject(2, 7, ME, 32'h2222);
    expect_dout("R6", 7, 'h2222, 1'b1);
    expect_tx("R7", 3, 7, 0);

    // R10 foreign or malformed packets dropped
    inject(0, 4, 2, (32'h90 << 4));
    inject(0, 4, ME, 32'h8000_0000 | (32'h90 << 4));
    repeat (8) @(negedge clk);
    chk(txq.size() == 0, "R10", "dropped packets cause no traffic", txq.size(), 0);

    // R8 round-robin after serving source 10
    inject(0, 10, ME, (32'h60 << 4));
    expect_tx("R8", 1, 10, 'h60);
    inject(0, 2, ME, (32'h70 << 4));
    inject(0, 12, ME, (32'h80 << 4));
    inject(2, 10, ME, 32'hAAAA);
    expect_dout("R8", 10, 'hAAAA, 1'b1);
    expect_tx("R7", 3, 10, 0);
    expect_tx("R8", 1, 12, 'h80);
    inject(2, 12, ME, 32'hBBBB);
    expect_dout("R8", 12, 'hBBBB, 1'b1);
    expect_tx("R7", 3, 12, 0);
    expect_tx("R8", 1, 2, 'h70);
    inject(2, 2, ME, 32'hCCCC);
    expect_dout("R8", 2, 'hCCCC, 1'b1);
    expect_tx("R7", 3, 2, 0);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule